// File: doc/BRIEF.md
# Identity-Checked APB Access Bridge

This bridge sits in front of a downstream APB segment whose slaves do no checking of their own. An upstream requester issues ordinary APB transfers. Each transfer also carries a 3-bit requester identity as a sideband, and privilege taken from the protection field. The protection field is decoded as follows: bit 0 set means privileged, bit 1 set means non-secure, bit 2 set means an instruction access. For every transfer the bridge forms a 4-bit class from identity and direction. It then looks up the class in a 16-bit allow mask held for each protected address window. Only a permitted transfer is replayed downstream.

A refused transfer never raises the downstream select. Instead the bridge finishes it upstream itself, with an error and a "blocked" response flag. Addresses that fall in no protected window pass straight through. The allow masks are loaded through a small configuration port, which can be frozen with a sticky lock until the next reset. Reset loads a deny-all policy.

Top module: `apb_guard_bridge`

## Requirements
- R1: After reset, every allow mask is zero, the lock is clear and `m_psel` is low. Every transfer into a protected window is therefore refused, including privileged ones.
- R2: A transfer whose address lies in no protected window is forwarded, whatever its identity, direction or privilege.
- R3: Inside a protected window, a privileged transfer (`s_pprot[0]`=1) is forwarded exactly when the mask bit indexed by the class `{s_mid, s_pwrite}` is set. Index = 2*identity + write.
- R4: Inside a protected window, a transfer with `s_pprot[0]`=0 is refused even when its class bit is set. This covers a user-level write to the thermal-limit window.
- R5: A refused transfer never asserts `m_psel`. It completes in its first upstream access cycle with `s_pready`=1, `s_pslverr`=1, `s_blocked`=1 and `s_prdata`=0.
- R6: A forwarded transfer runs one downstream setup cycle, in the cycle after the upstream setup, and then access cycles. It carries the upstream address, write data and direction unchanged. `m_prdata`, `m_pslverr` and completion are returned upstream, with `s_blocked`=0.
- R7: While unlocked, `cfg_we` writes `cfg_mask` into the mask of window `cfg_win` at the clock edge.
- R8: A `cfg_lock` pulse sets a lock that only reset clears. From the following edge onwards, `cfg_we` has no effect on any mask.
- R9: Downstream wait states stretch the upstream access phase one for one. A forwarded transfer spends (downstream wait cycles + 2) cycles in its upstream access phase, and the downstream signals stay asserted meanwhile.
- R10: All three protection bits are passed unchanged to `m_pprot` on forwarded transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_win | input | WW | Window selected for a mask write |
| cfg_mask | input | 16 | Allow mask value, bit i for class i |
| cfg_lock | input | 1 | Sets the sticky policy lock |
| s_psel | input | 1 | Upstream select |
| s_penable | input | 1 | Upstream enable |
| s_pwrite | input | 1 | Upstream direction, 1 = write |
| s_paddr | input | AW | Upstream address |
| s_pwdata | input | DW | Upstream write data |
| s_pprot | input | 3 | Protection: [0] privileged, [1] non-secure, [2] instruction |
| s_mid | input | 3 | Requester identity sideband |
| s_prdata | output | DW | Read data to requester |
| s_pready | output | 1 | Upstream completion |
| s_pslverr | output | 1 | Upstream error |
| s_blocked | output | 1 | Response attribute: transfer refused by policy |
| m_psel | output | 1 | Downstream select |
| m_penable | output | 1 | Downstream enable |
| m_pwrite | output | 1 | Downstream direction |
| m_paddr | output | AW | Downstream address |
| m_pwdata | output | DW | Downstream write data |
| m_pprot | output | 3 | Downstream protection |
| m_prdata | input | DW | Downstream read data |
| m_pready | input | 1 | Downstream completion |
| m_pslverr | input | 1 | Downstream error |

## Verification
A wrong mask bit or a bad window decode shows up on the transfer that reads it. That transfer either produces a downstream setup pulse it should not have, or completes after one access cycle with the blocked flag when it should have been forwarded. Sweeping all sixteen classes through each window, and outside them, exposes any single bad bit within one transfer. A lock that fails to hold shows up on the first transfer after a post-lock mask write. A sequencer stuck in the wrong state shows as an access phase of the wrong length, or as a hang caught by the watchdog.

// File: rtl/apb_guard_bridge.sv
module apb_guard_bridge #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IDW = 3,
  parameter int NWIN = 2,
  parameter int WIN_LG2 = 8,
  parameter logic [NWIN*AW-1:0] WIN_BASE = {32'h0000_2000, 32'h0000_1000},
  localparam int WW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int NCLS = 2 ** (IDW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [WW-1:0]   cfg_win,
  input  logic [NCLS-1:0] cfg_mask,
  input  logic            cfg_lock,
  input  logic            s_psel,
  input  logic            s_penable,
  input  logic            s_pwrite,
  input  logic [AW-1:0]   s_paddr,
  input  logic [DW-1:0]   s_pwdata,
  input  logic [2:0]      s_pprot,
  input  logic [IDW-1:0]  s_mid,
  output logic [DW-1:0]   s_prdata,
  output logic            s_pready,
  output logic            s_pslverr,
  output logic            s_blocked,
  output logic            m_psel,
  output logic            m_penable,
  output logic            m_pwrite,
  output logic [AW-1:0]   m_paddr,
  output logic [DW-1:0]   m_pwdata,
  output logic [2:0]      m_pprot,
  input  logic [DW-1:0]   m_prdata,
  input  logic            m_pready,
  input  logic            m_pslverr
);

  typedef enum logic [1:0] {ST_IDLE, ST_FSETUP, ST_FACC, ST_DENY} st_t;

  st_t             st;
  logic            locked;
  logic [NCLS-1:0] pol [NWIN];
  logic [NWIN-1:0] hit, permit;

  wire [IDW:0] cls     = {s_mid, s_pwrite};
  wire         is_priv = s_pprot[0];
  wire         setup   = s_psel && !s_penable;
  wire         refuse  = (|hit) && (!is_priv || |(hit & ~permit));

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit[w]    = s_paddr[AW-1:WIN_LG2] == WIN_BASE[w*AW+WIN_LG2 +: AW-WIN_LG2];
    assign permit[w] = pol[w][cls];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pol[w] <= '0;
      else if (cfg_we && !locked && cfg_win == WW'(w)) pol[w] <= cfg_mask;

    // R8
    pol_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(pol[w]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) locked <= 1'b0;
    else if (cfg_lock) locked <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_IDLE;
    else
      case (st)
        ST_IDLE:   if (setup) st <= refuse ? ST_DENY : ST_FSETUP;
        ST_FSETUP: st <= ST_FACC;
        ST_FACC:   if (m_pready) st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase

  assign m_psel    = (st == ST_FSETUP) || (st == ST_FACC);
  assign m_penable = (st == ST_FACC);
  assign m_pwrite  = s_pwrite;
  assign m_paddr   = s_paddr;
  assign m_pwdata  = s_pwdata;
  assign m_pprot   = s_pprot;

  wire fwd_done = (st == ST_FACC) && m_pready;
  assign s_blocked = (st == ST_DENY);
  assign s_pready  = s_blocked || fwd_done;
  assign s_pslverr = s_blocked || (fwd_done && m_pslverr);
  assign s_prdata  = (st == ST_FACC) ? m_prdata : '0;

  // R4
  user_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && setup && |hit && !s_pprot[0]) |=> (!m_psel && s_pready && s_pslverr));

  // R5
  deny_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_blocked |-> (!m_psel && s_prdata == '0));

  // R6
  enable_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_penable |-> m_psel);

  // R6
  setup_then_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_psel && !m_penable) |=> (m_psel && m_penable));

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_psel && m_penable && !m_pready) |=> (m_psel && m_penable));

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

endmodule

// File: tb/apb_guard_bridge_tb_top.sv
module apb_guard_bridge_tb_top;
  localparam logic [15:0] MASK0 = 16'hA5C3;
  localparam logic [15:0] MASK1 = 16'h3C0F;
  // {region[1:0], mid[2:0], write, prot[2:0], expect_blocked}
  localparam logic [9:0] TBL [8] = '{
    10'b00_000_0_001_0, 10'b00_000_1_000_1, 10'b00_001_0_001_1, 10'b00_111_1_011_0,
    10'b01_101_0_101_0, 10'b01_010_0_001_1, 10'b10_011_1_000_0, 10'b01_110_1_111_0};

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_lock = 0;
  logic [0:0] cfg_win = 0;
  logic [15:0] cfg_mask = 0;
  logic s_psel = 0, s_penable = 0, s_pwrite = 0;
  logic [31:0] s_paddr = 0, s_pwdata = 0;
  logic [2:0] s_pprot = 0, s_mid = 0;
  logic [31:0] s_prdata, m_paddr, m_pwdata, m_prdata;
  logic s_pready, s_pslverr, s_blocked, m_psel, m_penable, m_pwrite, m_pready, m_pslverr;
  logic [2:0] m_pprot;

  int nchk = 0, nbad = 0;
  int slv_wait = 0, acc_cnt = 0, psel_cnt = 0;
  logic slv_err = 0;
  logic [31:0] last_addr, last_wdata;
  logic last_write;
  logic [2:0] last_prot;

  always #2 clk = ~clk;

  apb_guard_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_mask(cfg_mask),
    .cfg_lock(cfg_lock), .s_psel(s_psel), .s_penable(s_penable), .s_pwrite(s_pwrite),
    .s_paddr(s_paddr), .s_pwdata(s_pwdata), .s_pprot(s_pprot), .s_mid(s_mid),
    .s_prdata(s_prdata), .s_pready(s_pready), .s_pslverr(s_pslverr), .s_blocked(s_blocked),
    .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite), .m_paddr(m_paddr),
    .m_pwdata(m_pwdata), .m_pprot(m_pprot), .m_prdata(m_prdata), .m_pready(m_pready),
    .m_pslverr(m_pslverr));

  assign m_pready  = m_psel && m_penable && (acc_cnt >= slv_wait);
  assign m_pslverr = slv_err && m_psel && m_penable;
  assign m_prdata  = m_psel ? (m_paddr ^ 32'h5A5A_0000) : 32'h0;

  always @(posedge clk) begin
    if (m_psel && m_penable && !m_pready) acc_cnt <= acc_cnt + 1;
    else acc_cnt <= 0;
    if (m_psel && !m_penable) psel_cnt <= psel_cnt + 1;
    if (m_psel && m_penable && m_pready) begin
      last_addr <= m_paddr; last_wdata <= m_pwdata;
      last_write <= m_pwrite; last_prot <= m_pprot;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] raddr(input int r, input int k);
    return (r == 0 ? 32'h1000 : r == 1 ? 32'h2000 : 32'h3000) + 32'((k * 4) & 8'hFC);
  endfunction

  task automatic cfg_write(input logic w, input logic [15:0] m);
    @(negedge clk); cfg_we = 1; cfg_win = w; cfg_mask = m;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic xfer(input logic [31:0] a, input logic wr, input logic [2:0] pr, input logic [2:0] id,
                      input logic [31:0] wd, output logic blk, output logic err,
                      output logic [31:0] rd, output int ncyc, output int npsel);
    int p0;
    p0 = psel_cnt;
    @(negedge clk);
    s_psel = 1; s_penable = 0; s_paddr = a; s_pwrite = wr; s_pprot = pr; s_mid = id; s_pwdata = wd;
    @(negedge clk); s_penable = 1; #1;
    ncyc = 1;
    while (!s_pready && ncyc < 60) begin
      @(negedge clk); #1; ncyc++;
    end
    blk = s_blocked; err = s_pslverr; rd = s_prdata;
    @(negedge clk); s_psel = 0; s_penable = 0;
    npsel = psel_cnt - p0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL R9 watchdog: actual=hung expected=complete");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic blk, err;
    logic [31:0] rd;
    int nc, np;
    bit exp_blk;
    logic [15:0] mk;

    repeat (3) @(negedge clk);
    chk(m_psel == 0, "R1 reset m_psel", 32'(m_psel), 0);
    chk(s_pready == 0, "R1 reset s_pready", 32'(s_pready), 0);
    rst_n = 1;

    // R1: deny-all after reset, every class privileged, both windows
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 16; c++) begin
        xfer(raddr(r, c), c[0], 3'b001, c[3:1], 32'h11, blk, err, rd, nc, np);
        chk(blk == 1 && np == 0, "R1 deny-all", {blk, np[30:0]}, 32'h8000_0000);
      end

    // R7
    cfg_write(1'b0, MASK0);
    cfg_write(1'b1, MASK1);

    // directed table
    for (int i = 0; i < 8; i++) begin
      xfer(raddr(int'(TBL[i][9:8]), i), TBL[i][4], TBL[i][3:1], TBL[i][7:5], 32'hC0DE_0000 + i,
           blk, err, rd, nc, np);
      chk(blk == TBL[i][0], "R3/R4/R7 table blocked", 32'(blk), 32'(TBL[i][0]));
      chk(np == (TBL[i][0] ? 0 : 1), "R5/R6 table setup pulses", 32'(np), TBL[i][0] ? 0 : 1);
    end

    // full sweep: 3 regions x 16 classes x privilege
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 16; c++)
        for (int p = 0; p < 2; p++) begin
          mk = (r == 0) ? MASK0 : MASK1;
          exp_blk = (r < 2) && (p == 0 || !mk[c]);
          xfer(raddr(r, c), c[0], {2'b00, p[0]}, c[3:1], 32'h77, blk, err, rd, nc, np);
          chk(blk == exp_blk, r == 2 ? "R2 sweep outside" : (p == 0 ? "R4 sweep user" : "R3 sweep class"),
              32'(blk), 32'(exp_blk));
          chk(np == (exp_blk ? 0 : 1), "R5 sweep no psel on deny", 32'(np), exp_blk ? 0 : 1);
          if (exp_blk) chk(err == 1 && rd == 0 && nc == 1, "R5 deny response", rd, 0);
        end

    // R9 wait states and R6 data return
    slv_wait = 3;
    xfer(32'h3080, 0, 3'b001, 3'd4, 32'h0, blk, err, rd, nc, np);
    chk(nc == 5, "R9 access cycles", 32'(nc), 5);
    chk(rd == (32'h3080 ^ 32'h5A5A_0000), "R6 read data", rd, 32'h3080 ^ 32'h5A5A_0000);
    chk(err == 0 && blk == 0, "R6 no error", {err, blk}, 0);
    slv_wait = 0; slv_err = 1;
    xfer(32'h1010, 1, 3'b111, 3'd7, 32'hDEAD_BEEF, blk, err, rd, nc, np);
    chk(err == 1 && blk == 0, "R6 error passed", {err, blk}, 2);
    chk(last_wdata == 32'hDEAD_BEEF && last_addr == 32'h1010 && last_write == 1,
        "R6 write forwarded", last_wdata, 32'hDEAD_BEEF);
    chk(last_prot == 3'b111, "R10 prot passed", 32'(last_prot), 7);
    chk(nc == 2, "R9 zero-wait access cycles", 32'(nc), 2);
    slv_err = 0;

    // R8 lock
    @(negedge clk); cfg_lock = 1; @(negedge clk); cfg_lock = 0;
    cfg_write(1'b0, 16'hFFFF);
    xfer(raddr(0, 1), 0, 3'b001, 3'd1, 32'h0, blk, err, rd, nc, np);
    chk(blk == 1 && np == 0, "R8 write after lock ignored", 32'(blk), 1);
    xfer(raddr(0, 2), 0, 3'b001, 3'd0, 32'h0, blk, err, rd, nc, np);
    chk(blk == 0, "R8 old mask kept", 32'(blk), 0);

    // reset clears lock and policy
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    xfer(raddr(0, 3), 0, 3'b001, 3'd0, 32'h0, blk, err, rd, nc, np);
    chk(blk == 1, "R1 deny-all after second reset", 32'(blk), 1);
    cfg_write(1'b0, 16'hFFFF);
    xfer(raddr(0, 4), 0, 3'b001, 3'd1, 32'h0, blk, err, rd, nc, np);
    chk(blk == 0 && np == 1, "R8 lock cleared by reset", 32'(blk), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule